// File: doc/BRIEF.md
# Thermal Clock Throttle Controller

This block picks the clock-slowdown setting for one clock domain: a 3-bit divisor and an 8-bit PWM duty value. The clock divider and the gating circuit that act on these values sit outside the block and only consume its outputs. A setting comes from one of two sources. The first is a software force register, which takes effect whenever its divisor field is nonzero. The second is a thermal-protection register, which takes effect by itself whenever a critical-temperature comparison is enabled and the current temperature is above the threshold.

Software writes three registers through a plain write strobe with a 2-bit address. A 16-bit status word shows which source is in effect, together with the divisor and duty actually applied. The thermal source always wins over the force source. The temperature comparison is evaluated again on every cycle, so throttling ends on its own once the temperature drops back to the threshold or below it. The block has no data stream, so all pins are plain control and status signals with no handshake.

Register map (address: content):
- 0, force: duty in bits 15:8, divisor in bits 2:0.
- 1, thermal setting: the same layout as the force register.
- 2, critical: enable in bit 31, threshold in bits 13:0.

Address 3 is not used.

Status word layout:
- bits 7:0: applied duty.
- bit 9: the force source is applied.
- bit 11: the thermal source is applied.
- bits 14:12: applied divisor.
- All other bits read 0.

Timing: a write sampled at a rising edge shows on the outputs at the following rising edge. A change of temperature shows on the outputs at the first rising edge after the change.

Top module: `thermal_throttle`

## Requirements
- R1: After reset, status_o, div_o and duty_o are all 0.
- R2: When the thermal source is not engaged, writing address 0 with a nonzero divisor D in bits 2:0 and duty N in bits 15:8 makes status_o read (D<<12) | 0x200 | N. For example, D=2 gives 0x2200 | N for every N from 0 to 255.
- R3: Writing address 0 with a divisor field of 0 releases the force. With the thermal source not engaged, status_o then reads 0.
- R4: When the enable bit (bit 31 of address 2) is set and temp_i is greater than the threshold (bits 13:0 of address 2), status_o reads (Dt<<12) | 0x800 | Nt. Here Dt and Nt are the divisor and duty fields of address 1.
- R5: A temperature equal to the threshold does not engage thermal protection. When the temperature falls to the threshold or below it, throttling is released on the next rising edge.
- R6: With the enable bit clear, no temperature engages thermal protection.
- R7: While thermal protection is engaged, status bit 9 is 0 even if the force is armed. When thermal protection releases, the armed force setting is applied again.
- R8: div_o always equals status_o bits 14:12, and duty_o always equals status_o bits 7:0.
- R9: A write to address 3 changes no register and no output.
- R10: Thermal-register divisor values 1 through 6 are applied exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 force, 1 thermal setting, 2 critical) |
| wr_data | input | 32 | Write data |
| temp_i | input | 14 | Current temperature |
| div_o | output | 3 | Applied clock divisor |
| duty_o | output | 8 | Applied PWM duty |
| status_o | output | 16 | Status word |

## Verification
Two events can land on the same rising edge: the thermal comparison crossing the threshold, and an armed force setting that is competing to be applied. The bench arms the force first. It then moves the temperature from the threshold to one step above it and back again, and separately moves it across the top code of the 14-bit range. After each step it checks the whole status word against a value worked out from the priority rule: the thermal fields with bit 11 set, or the force fields with bit 9 set, and never both flags together.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int DIV_W    = 3;
  localparam int DUTY_W   = 8;
  localparam int TEMP_W   = 14;
  localparam int ADDR_W   = 2;
  localparam int DATA_W   = 32;
  localparam int STAT_W   = 16;
  localparam int DUTY_LSB = 8;
  localparam int EN_BIT   = 31;
  localparam int ST_FORCE = 9;
  localparam int ST_THERM = 11;
  localparam int ST_DIV   = 12;

  typedef enum logic [ADDR_W-1:0] {
    SEL_FORCE = 2'd0,
    SEL_THERM = 2'd1,
    SEL_CRIT  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [DUTY_W-1:0] duty;
    logic [DIV_W-1:0]  div;
  } setting_t;
endpackage

// File: rtl/thr_regs.sv
module thr_regs
  import thr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output setting_t          force_set,
  output setting_t          therm_set,
  output logic              crit_en,
  output logic [TEMP_W-1:0] crit_thr
);
  setting_t wr_setting;
  logic     unused_hi;

  assign wr_setting.duty = wr_data[DUTY_LSB +: DUTY_W];
  assign wr_setting.div  = wr_data[DIV_W-1:0];
  assign unused_hi       = ^wr_data[EN_BIT-1:DUTY_LSB+DUTY_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      force_set <= '0;
      therm_set <= '0;
      crit_en   <= 1'b0;
      crit_thr  <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_addr))
        SEL_FORCE: force_set <= wr_setting;
        SEL_THERM: therm_set <= wr_setting;
        SEL_CRIT: begin
          crit_en  <= wr_data[EN_BIT];
          crit_thr <= wr_data[TEMP_W-1:0];
        end
        default: ;
      endcase
    end
  end

  a_r9_unused_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SEL_NONE) |=>
      ($stable(force_set) && $stable(therm_set) && $stable(crit_en) && $stable(crit_thr)));

  a_r3_force_release: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SEL_FORCE && wr_data[DIV_W-1:0] == '0) |=> (force_set.div == '0));
endmodule

// File: rtl/thr_compare.sv
module thr_compare
  import thr_pkg::*;
(
  input  logic [TEMP_W-1:0] temp,
  input  logic              crit_en,
  input  logic [TEMP_W-1:0] crit_thr,
  output logic              hot
);
  always_comb hot = crit_en && (temp > crit_thr);
endmodule

// File: rtl/thr_arbiter.sv
module thr_arbiter
  import thr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  setting_t          force_set,
  input  setting_t          therm_set,
  input  logic              hot,
  output logic [DIV_W-1:0]  div_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic [STAT_W-1:0] status_o
);
  logic          force_armed;
  setting_t      pick;
  logic [STAT_W-1:0] stat_next;

  always_comb begin
    force_armed = (force_set.div != '0);
    pick        = '0;
    stat_next   = '0;
    if (hot) begin
      pick                 = therm_set;
      stat_next[ST_THERM]  = 1'b1;
    end else if (force_armed) begin
      pick                 = force_set;
      stat_next[ST_FORCE]  = 1'b1;
    end
    stat_next[DUTY_W-1:0]          = pick.duty;
    stat_next[ST_DIV +: DIV_W]     = pick.div;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_o    <= '0;
      duty_o   <= '0;
      status_o <= '0;
    end else begin
      div_o    <= pick.div;
      duty_o   <= pick.duty;
      status_o <= stat_next;
    end
  end

  a_r4_thermal_applied: assert property (@(posedge clk) disable iff (!rst_n)
    hot |=> (status_o[ST_THERM] && div_o == $past(therm_set.div) && duty_o == $past(therm_set.duty)));

  a_r2_force_applied: assert property (@(posedge clk) disable iff (!rst_n)
    (!hot && force_set.div != '0) |=> (status_o[ST_FORCE] && div_o == $past(force_set.div)
                                      && duty_o == $past(force_set.duty)));

  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!hot && force_set.div == '0) |=> (status_o == '0));

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({status_o[ST_THERM], status_o[ST_FORCE]}));
endmodule

// File: rtl/thermal_throttle.sv
module thermal_throttle
  import thr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TEMP_W-1:0] temp_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic [STAT_W-1:0] status_o
);
  setting_t          force_set;
  setting_t          therm_set;
  logic              crit_en;
  logic [TEMP_W-1:0] crit_thr;
  logic              hot;

  thr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .force_set(force_set), .therm_set(therm_set), .crit_en(crit_en), .crit_thr(crit_thr)
  );

  thr_compare u_cmp (
    .temp(temp_i), .crit_en(crit_en), .crit_thr(crit_thr), .hot(hot)
  );

  thr_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .force_set(force_set), .therm_set(therm_set), .hot(hot),
    .div_o(div_o), .duty_o(duty_o), .status_o(status_o)
  );

  a_r8_div_field: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[ST_DIV +: DIV_W] == div_o) && (status_o[DUTY_W-1:0] == duty_o));

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (status_o == '0 && div_o == '0 && duty_o == '0));
endmodule

// File: tb/test_thermal_throttle.sv
module test_thermal_throttle;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [13:0] temp_i = '0;
  logic [2:0]  div_o;
  logic [7:0]  duty_o;
  logic [15:0] status_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #5 clk = ~clk;

  thermal_throttle i_thermal_throttle (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .temp_i(temp_i), .div_o(div_o), .duty_o(duty_o), .status_o(status_o)
  );

  // monitor: pops expectations and compares, away from the rising edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (status_o !== e) begin
        n_bad++;
        $display("FAIL %s status actual=%h expected=%h", t, status_o, e);
      end
      n_vec++;
      if (div_o !== e[14:12] || duty_o !== e[7:0]) begin  // R8
        n_bad++;
        $display("FAIL R8 div/duty actual=%h/%h expected=%h/%h", div_o, duty_o, e[14:12], e[7:0]);
      end
    end
  end

  task automatic push(input logic [15:0] e, input string t);
    @(posedge clk);
    #1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_temp(input logic [13:0] t);
    @(negedge clk);
    temp_i = t;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push(16'h0000, "R1 reset");

    for (int n = 0; n < 256; n++) begin
      wr(2'd0, (n << 8) | 2);
      push(16'h2200 | n[15:0], "R2 duty sweep");
    end
    for (int d = 1; d < 4; d++) begin
      wr(2'd0, d);
      push(16'(d << 12) | 16'h0200, "R2 divisor");
    end
    wr(2'd0, 32'h0000_7700);
    push(16'h0000, "R3 force release");

    wr(2'd0, 32'h0000_3305);
    push(16'h5233, "R2 armed");
    wr(2'd3, 32'hFFFF_FFFF);
    push(16'h5233, "R9 unused address");

    wr(2'd1, 32'h0000_8004);
    wr(2'd2, 32'h8000_0000 | 1000);
    set_temp(14'd1000);
    push(16'h5233, "R5 equal not hot");
    set_temp(14'd1001);
    push(16'h4880, "R4/R7 thermal over force");
    set_temp(14'd1000);
    push(16'h5233, "R5/R7 release to force");

    wr(2'd2, 32'h0000_0000 | 10);
    set_temp(14'd2000);
    push(16'h5233, "R6 disabled");

    wr(2'd0, 32'h0);
    wr(2'd2, 32'h8000_0000 | 14'h3ffe);
    set_temp(14'h3fff);
    for (int d = 1; d < 7; d++) begin
      wr(2'd1, ((17 * d) << 8) | d);
      push(16'(d << 12) | 16'h0800 | 16'(17 * d), "R10 thermal divisor");
    end
    wr(2'd2, 32'h8000_0000 | 14'h3fff);
    push(16'h0000, "R5 top threshold");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule